// File: doc/BRIEF.md
# Block-Matching SAD Accumulator with Early Exit

This block scores one candidate reference block against the current block for motion estimation. It takes eight unsigned 8-bit pixels from each block on every accepted beat. It forms the absolute difference in each lane, sums the eight lane values in the same cycle, and adds that sum to a 16-bit running total. A 16x16 block arrives as 32 beats: two beats per row for sixteen rows.

A start pulse opens a candidate and latches a threshold energy and its enable bit. With the threshold enabled, the running total is tested after every beat. As soon as the total goes above the threshold, the candidate is rejected and the remaining beats are not consumed. A search controller can therefore drop a poor candidate early and save the rest of its cycles. With the threshold disabled, the full block is always summed.

Top module: `sad_early_exit`

## Requirements
- R1: After reset, `in_ready_o`, `done_o` and `aborted_o` are low and `sad_o` is zero.
- R2: A `start_i` pulse clears the total and the beat count, and latches `thr_i` and `thr_en_i`. On the next cycle `in_ready_o` is high and `sad_o` is zero.
- R3: A beat is accepted when `in_valid_i` and `in_ready_o` are both high. Lane i sits at bits [8i+7:8i] of `cur_pix_i` and `ref_pix_i`. The sum over all eight lanes of |cur - ref| is added to the total, and the new total appears on `sad_o` in the cycle after acceptance.
- R4: The total is 16 bits wide and never wraps. Sixteen-by-sixteen blocks of 255 against 0 give 65280.
- R5: With the threshold disabled, exactly 32 beats are accepted. `done_o` pulses in the cycle after the 32nd beat, `aborted_o` stays low, and `sad_o` holds the full total.
- R6: With the threshold enabled, the first beat that makes the total strictly greater than the latched threshold ends the candidate. `done_o` and `aborted_o` pulse together in the next cycle, and `sad_o` shows the partial total.
- R7: A total equal to the latched threshold does not reject the candidate.
- R8: `done_o` and `aborted_o` last one cycle. From `done_o` until the next start, `in_ready_o` is low, input beats are ignored, and `sad_o` holds its value.
- R9: Cycles with `in_valid_i` low leave the total and the beat count unchanged.
- R10: A start during a candidate restarts it from zero. A beat offered in the same cycle as a start is discarded.
- R11: Changes to `thr_i` or `thr_en_i` after the start pulse have no effect on the running candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new candidate |
| thr_en_i | input | 1 | Threshold enable, latched at start |
| thr_i | input | 16 | Threshold energy, latched at start |
| in_valid_i | input | 1 | Pixel beat valid |
| in_ready_o | output | 1 | Beat can be accepted |
| cur_pix_i | input | 64 | Eight current-block pixels |
| ref_pix_i | input | 64 | Eight reference-block pixels |
| done_o | output | 1 | One-cycle end-of-candidate pulse |
| aborted_o | output | 1 | One-cycle rejection pulse, coincides with done |
| sad_o | output | 16 | Running or final sum of absolute differences |

## Verification
Every result is registered one edge after its cause. `sad_o` and `done_o`/`aborted_o` change in the cycle after the accepting beat, and `in_ready_o` rises in the cycle after start. The bench drives inputs on the falling edge and checks on the next falling edge, so each check lands exactly one register stage after its stimulus. A software model running the same beats in parallel gives the expected partial total and the expected finishing beat. After each finish, three more cycles of offered input are checked to confirm the pulses have cleared and the total is frozen.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int LANES_DEF  = 8;
    localparam int PIX_W_DEF  = 8;
    localparam int BLK_DIM    = 16;
    localparam int BEATS_DEF  = BLK_DIM * BLK_DIM / LANES_DEF;
    localparam int ACC_W_DEF  = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sad_state_e;
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    output logic [PIX_W-1:0] d_o
);
    always_comb begin
        if (a_i >= b_i) d_o = a_i - b_i;
        else            d_o = b_i - a_i;
    end
endmodule

// File: rtl/sad_hsum.sv
module sad_hsum #(
    parameter int N     = 8,
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + $clog2(N)
) (
    input  logic [N*IN_W-1:0] vals_i,
    output logic [OUT_W-1:0]  sum_o
);
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < N; i++) begin
            sum_o = sum_o + OUT_W'(vals_i[i*IN_W +: IN_W]);
        end
    end
endmodule

// File: rtl/sad_early_exit.sv
module sad_early_exit
    import sad_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int PIX_W = PIX_W_DEF,
    parameter int BEATS = BEATS_DEF,
    parameter int ACC_W = ACC_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   thr_en_i,
    input  logic [ACC_W-1:0]       thr_i,
    input  logic                   in_valid_i,
    output logic                   in_ready_o,
    input  logic [LANES*PIX_W-1:0] cur_pix_i,
    input  logic [LANES*PIX_W-1:0] ref_pix_i,
    output logic                   done_o,
    output logic                   aborted_o,
    output logic [ACC_W-1:0]       sad_o
);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BSUM_W = PIX_W + $clog2(LANES);

    typedef struct packed {
        sad_state_e        st;
        logic [BEAT_W-1:0] beat;
        logic [ACC_W-1:0]  acc;
        logic [ACC_W-1:0]  thr;
        logic              thr_en;
        logic              done;
        logic              aborted;
    } core_s;

    core_s r_d, r_q;

    logic [LANES*PIX_W-1:0] lane_diff;
    logic [BSUM_W-1:0]      beat_sum;
    logic [ACC_W-1:0]       acc_sum;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sad_absdiff #(.PIX_W(PIX_W)) u_diff (
            .a_i (cur_pix_i[g*PIX_W +: PIX_W]),
            .b_i (ref_pix_i[g*PIX_W +: PIX_W]),
            .d_o (lane_diff[g*PIX_W +: PIX_W])
        );
    end

    sad_hsum #(.N(LANES), .IN_W(PIX_W), .OUT_W(BSUM_W)) u_hsum (
        .vals_i (lane_diff),
        .sum_o  (beat_sum)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.aborted = 1'b0;
        acc_sum     = r_q.acc + ACC_W'(beat_sum);
        if (start_i) begin
            r_d.st     = ST_RUN;
            r_d.beat   = '0;
            r_d.acc    = '0;
            r_d.thr    = thr_i;
            r_d.thr_en = thr_en_i;
        end else if (r_q.st == ST_RUN && in_valid_i) begin
            r_d.acc = acc_sum;
            if (r_q.thr_en && (acc_sum > r_q.thr)) begin
                r_d.st      = ST_IDLE;
                r_d.done    = 1'b1;
                r_d.aborted = 1'b1;
            end else if (r_q.beat == BEAT_W'(BEATS - 1)) begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end else begin
                r_d.beat = r_q.beat + BEAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, beat: '0, acc: '0, thr: '0,
                     thr_en: 1'b0, done: 1'b0, aborted: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    logic [ACC_W-1:0] thr_lat;
    logic             thr_en_lat;
    assign thr_lat    = r_q.thr;
    assign thr_en_lat = r_q.thr_en;

    assign in_ready_o = (r_q.st == ST_RUN);
    assign done_o     = r_q.done;
    assign aborted_o  = r_q.aborted;
    assign sad_o      = r_q.acc;
endmodule

// File: rtl/sad_early_exit_chk.sv
module sad_early_exit_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_ready_o,
    input logic             done_o,
    input logic             aborted_o,
    input logic [ACC_W-1:0] sad_o,
    input logic [ACC_W-1:0] thr_lat,
    input logic             thr_en_lat
);
    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (in_ready_o && sad_o == '0));

    // R6
    abort_flags_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |-> done_o);

    // R6
    abort_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |-> (thr_en_lat && sad_o > thr_lat));

    // R7
    finish_within_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !aborted_o) |-> (!thr_en_lat || sad_o <= thr_lat));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    ready_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready_o);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (sad_o >= $past(sad_o)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && !start_i) |=> $stable(sad_o));
endmodule

bind sad_early_exit sad_early_exit_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_ready_o (in_ready_o),
    .done_o     (done_o),
    .aborted_o  (aborted_o),
    .sad_o      (sad_o),
    .thr_lat    (thr_lat),
    .thr_en_lat (thr_en_lat)
);

// File: tb/sad_early_exit_tb.sv
`timescale 1ns/1ps
module sad_early_exit_tb;
    localparam int NB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        thr_en_i = 1'b0;
    logic [15:0] thr_i = '0;
    logic        in_valid_i = 1'b0;
    logic        in_ready_o;
    logic [63:0] cur_pix_i = '0;
    logic [63:0] ref_pix_i = '0;
    logic        done_o;
    logic        aborted_o;
    logic [15:0] sad_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] cur_m [NB][8];
    logic [7:0] ref_m [NB][8];

    always #2.5 clk = ~clk;

    sad_early_exit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .thr_en_i(thr_en_i),
        .thr_i(thr_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
        .cur_pix_i(cur_pix_i), .ref_pix_i(ref_pix_i), .done_o(done_o),
        .aborted_o(aborted_o), .sad_o(sad_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int beat_sum(input int b);
        int s = 0;
        for (int l = 0; l < 8; l++)
            s += (cur_m[b][l] > ref_m[b][l]) ? cur_m[b][l] - ref_m[b][l]
                                             : ref_m[b][l] - cur_m[b][l];
        return s;
    endfunction

    function automatic int block_sum();
        int s = 0;
        for (int b = 0; b < NB; b++) s += beat_sum(b);
        return s;
    endfunction

    task automatic put_beat(input int b);
        for (int l = 0; l < 8; l++) begin
            cur_pix_i[l*8 +: 8] = cur_m[b][l];
            ref_pix_i[l*8 +: 8] = ref_m[b][l];
        end
    endtask

    // Runs one candidate and checks every beat against the model.
    task automatic run_block(input bit en, input int thr, input int stall_pct);
        int acc = 0;
        int stop = NB - 1;
        bit ab = 0;
        int b = 0;
        for (int i = 0; i < NB; i++) begin
            acc += beat_sum(i);
            if (en && acc > thr) begin stop = i; ab = 1; break; end
        end
        acc = 0;
        @(negedge clk);
        start_i = 1; thr_en_i = en; thr_i = 16'(thr); in_valid_i = 0;
        @(negedge clk);
        start_i = 0;
        thr_i = 16'($urandom);      // R11: later changes must not matter
        thr_en_i = ~en;
        chk(in_ready_o == 1 && sad_o == 0, "R2", sad_o, 0);
        while (b <= stop) begin
            if (($urandom % 100) < stall_pct) begin
                in_valid_i = 0;
                cur_pix_i = {$urandom, $urandom};
                @(negedge clk);
                chk(sad_o == 16'(acc) && !done_o, "R9", sad_o, acc);
            end else begin
                in_valid_i = 1;
                put_beat(b);
                @(negedge clk);
                acc += beat_sum(b);
                chk(sad_o == 16'(acc), "R3", sad_o, acc);
                chk(done_o == (b == stop), en ? "R6" : "R5", done_o, b == stop);
                chk(aborted_o == (ab && b == stop), ab ? "R6" : "R7", aborted_o, ab && b == stop);
                b++;
            end
        end
        for (int k = 0; k < 3; k++) begin
            in_valid_i = 1;
            cur_pix_i = {$urandom, $urandom};
            ref_pix_i = {$urandom, $urandom};
            @(negedge clk);
            chk(!done_o && !aborted_o && !in_ready_o && sad_o == 16'(acc),
                "R8", sad_o, acc);
        end
        in_valid_i = 0;
    endtask

    task automatic fill_random();
        for (int b = 0; b < NB; b++)
            for (int l = 0; l < 8; l++) begin
                cur_m[b][l] = 8'($urandom);
                ref_m[b][l] = 8'($urandom);
            end
    endtask

    task automatic t_reset();
        chk(!in_ready_o && !done_o && !aborted_o && sad_o == 0, "R1", sad_o, 0);
    endtask

    task automatic t_identical();
        fill_random();
        for (int b = 0; b < NB; b++)
            for (int l = 0; l < 8; l++) ref_m[b][l] = cur_m[b][l];
        run_block(0, 0, 0);
        chk(sad_o == 0, "R5", sad_o, 0);
    endtask

    task automatic t_maxdiff();
        for (int b = 0; b < NB; b++)
            for (int l = 0; l < 8; l++) begin
                cur_m[b][l] = (b % 2) ? 8'd0 : 8'd255;
                ref_m[b][l] = (b % 2) ? 8'd255 : 8'd0;
            end
        run_block(0, 0, 20);
        chk(sad_o == 16'd65280, "R4", sad_o, 65280);
    endtask

    task automatic t_random_full();
        for (int r = 0; r < 4; r++) begin
            fill_random();
            run_block(0, 0, 30);
            chk(sad_o == 16'(block_sum()), "R5", sad_o, block_sum());
        end
    endtask

    task automatic t_abort();
        for (int r = 0; r < 4; r++) begin
            fill_random();
            run_block(1, block_sum() / (r + 2), 15);
        end
    endtask

    task automatic t_equal();
        fill_random();
        run_block(1, block_sum(), 0);
        chk(sad_o == 16'(block_sum()), "R7", sad_o, block_sum());
        run_block(1, block_sum() - 1, 0);
    endtask

    task automatic t_restart();
        fill_random();
        @(negedge clk);
        start_i = 1; thr_en_i = 0;
        @(negedge clk);
        start_i = 0;
        for (int b = 0; b < 5; b++) begin
            in_valid_i = 1; put_beat(b);
            @(negedge clk);
        end
        start_i = 1; in_valid_i = 1;
        cur_pix_i = {64{1'b1}}; ref_pix_i = '0;
        @(negedge clk);
        start_i = 0; in_valid_i = 0;
        chk(sad_o == 0 && in_ready_o, "R10", sad_o, 0);
        for (int b = 0; b < 3; b++) begin
            in_valid_i = 1; put_beat(b);
            @(negedge clk);
        end
        in_valid_i = 0;
        chk(sad_o == 16'(beat_sum(0) + beat_sum(1) + beat_sum(2)), "R10",
            sad_o, beat_sum(0) + beat_sum(1) + beat_sum(2));
        run_block(0, 0, 10);   // R10: start arrives while running
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_identical();
        t_maxdiff();
        t_random_full();
        t_abort();
        t_equal();
        t_restart();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule